// File: doc/BRIEF.md
# CPU Variant Detector

This block runs before a boot loader starts. It takes control of the data bus of an attached 8-bit CPU and works out whether the CPU is the original NMOS part or the later CMOS part. The test relies on a known difference between the two. The NMOS part's indirect jump does not carry into the high byte when the pointer sits at the last byte of a page. The CMOS part does carry.

After `start`, the block answers the CPU's next three read cycles with an indirect jump opcode and a pointer operand of $00FF. It then watches the addresses of the two pointer fetches. The first fetch is at $00FF. A later read at $0000 means the NMOS part is present. A later read at $0100 means the CMOS part is present. Both pointer fetches are answered with fixed bytes, so the CPU then jumps to a known target. The registered result selects one of two boot images. If the pointer phase takes too many read cycles without a result, the block ends with an error.

Top module: `cpu_variant_detect`

## Requirements
- R1: While reset is held and right after it, `done`, `is_cmos`, `err` and `data_oe` are all 0.
- R2: Before `start` is sampled high, no read cycle is driven (`data_oe` = 0) and the result outputs stay 0.
- R3: After `start`, the first three read cycles (`bus_cyc`=1, `cpu_rw`=1) are driven, in order, with $6C, $FF and $00. Write cycles in between are not driven and do not advance the sequence.
- R4: In the pointer phase, a read at $00FF is driven with `TGT_LO` (default $00). The resolving read at $0000 or $0100 is driven with `TGT_HI` (default $02).
- R5: If a read at $00FF is followed later by a read at $0000, then from the next clock on `done`=1, `is_cmos`=0 and `err`=0.
- R6: If a read at $00FF is followed later by a read at $0100, then from the next clock on `done`=1, `is_cmos`=1 and `err`=0.
- R7: In the pointer phase, reads at other addresses are not driven and do not resolve the test. This includes a read at $0000 or $0100 that comes before any read at $00FF.
- R8: If the `TIMEOUT`-th read cycle (default 8) after the third operand byte does not resolve the test, then from the next clock on `done`=1, `err`=1 and `is_cmos`=0.
- R9: Once `done` is 1, it stays 1 and `is_cmos` and `err` hold their values until reset. No further cycle is driven, and `start` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins detection when sampled high in the idle state |
| bus_cyc | input | 1 | High for exactly one clock per CPU bus cycle |
| cpu_rw | input | 1 | 1 = read cycle, 0 = write cycle |
| cpu_addr | input | 16 | CPU address bus |
| data_out | output | 8 | Byte presented to the CPU on driven reads |
| data_oe | output | 1 | Data bus drive enable |
| done | output | 1 | Detection finished (sticky) |
| is_cmos | output | 1 | 1 = CMOS variant found |
| err | output | 1 | Detection timed out |

## Verification
The hardest case to reach is the CMOS part's extra pointer-phase traffic. This means a repeat read of $00FF, reads at unrelated addresses, and a read at $0100 or $0000 arriving before the pointer fetch has even started. The bench plays these bus cycles directly from tasks to build such orderings, then checks that only a read at the wrapped or carried address that follows $00FF settles the result. The timeout is pushed to its exact edge by comparing the state one read before the limit with the state at the limit.

// File: rtl/cpu_variant_detect.sv
module cpu_variant_detect #(
  parameter int unsigned TIMEOUT = 8,
  parameter logic [7:0]  TGT_LO  = 8'h00,
  parameter logic [7:0]  TGT_HI  = 8'h02
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        bus_cyc,
  input  logic        cpu_rw,
  input  logic [15:0] cpu_addr,
  output logic [7:0]  data_out,
  output logic        data_oe,
  output logic        done,
  output logic        is_cmos,
  output logic        err
);

  localparam int CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam logic [7:0] OP_JMPI = 8'h6C;

  typedef enum logic [2:0] {ST_IDLE, ST_OPC, ST_OPL, ST_OPH, ST_PTR1, ST_PTR2, ST_FIN} st_t;

  st_t         st;
  logic [CW-1:0] cnt;

  wire rd      = bus_cyc && cpu_rw;
  wire at_ptr  = (cpu_addr == 16'h00FF);
  wire at_wrap = (cpu_addr == 16'h0000);
  wire at_carry= (cpu_addr == 16'h0100);
  wire in_ptr  = (st == ST_PTR1) || (st == ST_PTR2);
  wire resolve = (st == ST_PTR2) && (at_wrap || at_carry);

  always_comb begin
    data_oe  = 1'b0;
    data_out = 8'h00;
    if (rd) begin
      case (st)
        ST_OPC: begin data_oe = 1'b1; data_out = OP_JMPI; end
        ST_OPL: begin data_oe = 1'b1; data_out = 8'hFF;   end
        ST_OPH: begin data_oe = 1'b1; data_out = 8'h00;   end
        ST_PTR1, ST_PTR2: begin
          if (at_ptr) begin
            data_oe  = 1'b1;
            data_out = TGT_LO;
          end else if (resolve) begin
            data_oe  = 1'b1;
            data_out = TGT_HI;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      done    <= 1'b0;
      is_cmos <= 1'b0;
      err     <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) st <= ST_OPC;
        ST_OPC:  if (rd) st <= ST_OPL;
        ST_OPL:  if (rd) st <= ST_OPH;
        ST_OPH:  if (rd) begin
          st  <= ST_PTR1;
          cnt <= '0;
        end
        ST_PTR1, ST_PTR2: if (rd) begin
          if (resolve) begin
            st      <= ST_FIN;
            done    <= 1'b1;
            is_cmos <= at_carry;
          end else if (cnt == CW'(TIMEOUT - 1)) begin
            st   <= ST_FIN;
            done <= 1'b1;
            err  <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
            if (at_ptr) st <= ST_PTR2;
          end
        end
        default: ;
      endcase
    end
  end

  AST_OE_READ_ONLY:   assert property (@(posedge clk) disable iff (!rst_n) data_oe |-> (bus_cyc && cpu_rw)); // R3
  AST_DONE_STICKY:    assert property (@(posedge clk) disable iff (!rst_n) done |=> done); // R9
  AST_RESULT_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) done |=> ($stable(is_cmos) && $stable(err))); // R9
  AST_NO_DRIVE_DONE:  assert property (@(posedge clk) disable iff (!rst_n) done |-> !data_oe); // R9
  AST_ERR_EXCLUSIVE:  assert property (@(posedge clk) disable iff (!rst_n) err |-> (done && !is_cmos)); // R8
  AST_CMOS_ON_CARRY:  assert property (@(posedge clk) disable iff (!rst_n) $rose(is_cmos) |-> $past(cpu_addr == 16'h0100 && rd)); // R6
  AST_PTR_BOUND:      assert property (@(posedge clk) disable iff (!rst_n) in_ptr |-> (cnt <= CW'(TIMEOUT - 1))); // R8

endmodule

// File: tb/cpu_variant_detect_bench.sv
module cpu_variant_detect_bench;
  logic clk = 0, rst_n = 0, start = 0, bus_cyc = 0, cpu_rw = 1;
  logic [15:0] cpu_addr = '0;
  logic [7:0] data_out;
  logic data_oe, done, is_cmos, err;
  logic [7:0] got_d;
  logic got_oe;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  cpu_variant_detect u_cpu_variant_detect (
    .clk(clk), .rst_n(rst_n), .start(start), .bus_cyc(bus_cyc), .cpu_rw(cpu_rw),
    .cpu_addr(cpu_addr), .data_out(data_out), .data_oe(data_oe),
    .done(done), .is_cmos(is_cmos), .err(err));

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a);
    @(negedge clk); bus_cyc = 1; cpu_rw = 1; cpu_addr = a; #1;
    got_oe = data_oe; got_d = data_out;
  endtask

  task automatic wr(input logic [15:0] a);
    @(negedge clk); bus_cyc = 1; cpu_rw = 0; cpu_addr = a; #1;
    got_oe = data_oe; got_d = data_out;
  endtask

  task automatic idle;
    @(negedge clk); bus_cyc = 0; cpu_rw = 1; #1;
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 0; bus_cyc = 0; start = 0;
    @(negedge clk); @(negedge clk); rst_n = 1; #1;
  endtask

  task automatic go;
    @(negedge clk); start = 1; @(negedge clk); start = 0;
  endtask

  task automatic res(input bit d, input bit c, input bit e, input string req);
    chk(done == d && is_cmos == c && err == e, req, {13'd0, done, is_cmos, err}, {13'd0, d, c, e});
  endtask

  task automatic feed_ops;
    go();
    rd(16'hFFFC); chk(got_oe && got_d == 8'h6C, "R3 opcode", {7'd0, got_oe, got_d}, 16'h016C);
    wr(16'h01FD); chk(!got_oe, "R3 write ignored", {15'd0, got_oe}, 0);
    rd(16'hFFFD); chk(got_oe && got_d == 8'hFF, "R3 operand lo", {7'd0, got_oe, got_d}, 16'h01FF);
    rd(16'hFFFE); chk(got_oe && got_d == 8'h00, "R3 operand hi", {7'd0, got_oe, got_d}, 16'h0100);
  endtask

  task automatic t_reset;
    rst_n = 0; #1;
    @(negedge clk); @(negedge clk); #1;
    res(0, 0, 0, "R1 reset");
    chk(!data_oe, "R1 oe", {15'd0, data_oe}, 0);
    rst_n = 1;
  endtask

  task automatic t_idle;
    do_reset();
    rd(16'hFFFC); chk(!got_oe, "R2 no drive before start", {15'd0, got_oe}, 0);
    idle(); res(0, 0, 0, "R2 idle result");
  endtask

  task automatic t_nmos;
    do_reset(); feed_ops();
    rd(16'h00FF); chk(got_oe && got_d == 8'h00, "R4 ptr lo", {7'd0, got_oe, got_d}, 16'h0100);
    rd(16'h0000); chk(got_oe && got_d == 8'h02, "R4 ptr hi", {7'd0, got_oe, got_d}, 16'h0102);
    idle(); res(1, 0, 0, "R5 nmos");
  endtask

  task automatic t_cmos;
    do_reset(); feed_ops();
    rd(16'h00FF);
    rd(16'h00FF); chk(got_oe && got_d == 8'h00, "R4 repeat ptr lo", {7'd0, got_oe, got_d}, 16'h0100);
    rd(16'h3456); chk(!got_oe, "R7 other addr", {15'd0, got_oe}, 0);
    idle(); res(0, 0, 0, "R7 unresolved");
    rd(16'h0100); chk(got_oe && got_d == 8'h02, "R4 ptr hi cmos", {7'd0, got_oe, got_d}, 16'h0102);
    idle(); res(1, 1, 0, "R6 cmos");
  endtask

  task automatic t_order;
    do_reset(); feed_ops();
    rd(16'h0100); chk(!got_oe, "R7 early carry addr", {15'd0, got_oe}, 0);
    rd(16'h0000); chk(!got_oe, "R7 early wrap addr", {15'd0, got_oe}, 0);
    idle(); res(0, 0, 0, "R7 early no result");
    rd(16'h00FF); rd(16'h0100);
    idle(); res(1, 1, 0, "R6 cmos after early reads");
  endtask

  task automatic t_timeout;
    do_reset(); feed_ops();
    for (int i = 0; i < 7; i++) rd(16'h1234);
    idle(); res(0, 0, 0, "R8 before limit");
    rd(16'h1234);
    idle(); res(1, 0, 1, "R8 timeout");
  endtask

  task automatic t_sticky;
    do_reset(); feed_ops();
    rd(16'h00FF); rd(16'h0000); idle();
    go();
    rd(16'hFFFC); chk(!got_oe, "R9 no drive after done", {15'd0, got_oe}, 0);
    rd(16'h00FF); chk(!got_oe, "R9 ptr ignored after done", {15'd0, got_oe}, 0);
    rd(16'h0100); idle();
    res(1, 0, 0, "R9 result held");
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_nmos();
    t_cmos();
    t_order();
    t_timeout();
    t_sticky();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule